// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a three-wire serial slave that holds seven 11-bit configuration words for a clock-synthesis datapath. A host drives a serial clock, an active-low select and a data line. While select is low, every rising serial-clock edge shifts one bit into a 15-bit frame. The first rising edge seen with select high commits that frame. A write frame stores its data word. A read frame loads the addressed word back into the frame register and turns the data line around. The block then returns the address and data during the next low-select frame.

The three serial inputs are brought into the system clock domain through a synchroniser chain. All frame handling and all storage live on the system clock, so the parallel configuration outputs can be used there directly. The data line is split into an input, an output and an output-enable, and a pad outside the block joins them.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset the words hold the following values: word 0 = 0x04F, word 1 = 0x003, word 2 = 0x006, word 3 = 0x013, word 4 = 0x5DC, word 5 = 0x5C1 and word 6 = 0x047. Bit 10 of words 4 and 5 is 1. Word n appears on `cfg_flat[11n+10:11n]`.
- R2: A frame is sent in this order: a command flag, then a 3-bit address LSB first, then an 11-bit data word LSB first. A flag of 0 means write and a flag of 1 means read.
- R3: The first rising serial-clock edge with select high that follows at least one shifted bit commits the frame. On a write, the addressed word takes the data. The data input is ignored on that edge.
- R4: Further rising serial-clock edges while select stays high have no effect. A pending readout stays armed and its output stays enabled.
- R5: When a read commits, `ser_doe` rises. In the next low-select frame, `ser_dout` presents 14 bits, LSB first: the 3 address bits, then the 11 data bits. Address bit 0 is on the pin before the first rising edge, and each rising edge advances the pin by one bit.
- R6: The commit edge that ends the readout frame drops `ser_doe` and writes nothing, whatever was shifted in during that frame.
- R7: A write to address 7 changes no word. A read of address 7 returns address 7 with an all-zero data word.
- R8: When more than 15 bits are shifted before a commit, only the last 15 bits form the frame.
- R9: `ser_dout` is 0 while `ser_doe` is low. `ser_doe` is low after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_sel_n | input | 1 | Active-low frame select |
| ser_din | input | 1 | Serial data from the pad |
| ser_dout | output | 1 | Serial data driven back to the pad |
| ser_doe | output | 1 | Output enable for the data pad |
| cfg_flat | output | 77 | Seven 11-bit configuration words, word 0 in the low bits |

## Verification
The hardest situation to reach is the second frame of a read. In that frame the pin belongs to the block, yet the data input keeps clocking bits into the same frame register. A design that forgets it is mid-read would treat those bits as a fresh command. The stimulus drives a complete, valid write command on the data input during every readout frame. Any spurious commit then shows up as a changed word on the parallel outputs. Extra high-select edges are inserted between the two halves of a read, which shows that the readout neither commits early nor loses its output enable.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;

   localparam int unsigned CFG_WORD_W  = 11;
   localparam int unsigned CFG_ADDR_W  = 3;
   localparam int unsigned CFG_WORDS   = 7;
   localparam int unsigned CFG_SYNC_N  = 2;

   // Power-up contents of each configuration word.
   function automatic logic [CFG_WORD_W-1:0] cfg_reset_value(input int unsigned idx);
      logic [CFG_WORD_W-1:0] v;
      case (idx)
         0:       v = 11'h04F;
         1:       v = 11'h003;
         2:       v = 11'h006;
         3:       v = 11'h013;
         4:       v = 11'h5DC;
         5:       v = 11'h5C1;
         6:       v = 11'h047;
         default: v = '0;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/cfg_serial_sync.sv
module cfg_serial_sync #(
   parameter int unsigned   W       = 3,
   parameter int unsigned   STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/cfg_serial_frame.sv
module cfg_serial_frame #(
   parameter int unsigned DATA_W = 11,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              sel_n_s,
   input  logic              din_s,
   input  logic [DATA_W-1:0] rd_data,
   output logic              wr_en,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [DATA_W-1:0] cmd_data,
   output logic              ser_dout,
   output logic              ser_doe
);

   localparam int unsigned FW = 1 + ADDR_W + DATA_W;

   logic          sclk_q;
   logic          rise;
   logic          commit;
   logic          armed;
   logic          rd_active;
   logic [FW-1:0] sr;

   assign rise     = sclk_s & ~sclk_q;
   assign commit   = rise & sel_n_s & armed;
   assign cmd_addr = sr[ADDR_W:1];
   assign cmd_data = sr[FW-1:ADDR_W+1];
   assign wr_en    = commit & ~rd_active & ~sr[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q    <= 1'b0;
         sr        <= '0;
         armed     <= 1'b0;
         rd_active <= 1'b0;
      end else begin
         sclk_q <= sclk_s;
         if (rise && !sel_n_s) begin
            // LSB-first frame: newest bit enters at the top.
            sr    <= {din_s, sr[FW-1:1]};
            armed <= 1'b1;
         end else if (commit) begin
            armed <= 1'b0;
            if (rd_active) begin
               rd_active <= 1'b0;
            end else if (sr[0]) begin
               sr        <= {1'b0, rd_data, sr[ADDR_W:1]};
               rd_active <= 1'b1;
            end
         end
      end
   end

   assign ser_doe  = rd_active;
   assign ser_dout = rd_active & sr[0];

endmodule

// File: rtl/cfg_serial_regs.sv
module cfg_serial_regs
   import cfg_serial_pkg::*;
#(
   parameter int unsigned DATA_W   = 11,
   parameter int unsigned ADDR_W   = 3,
   parameter int unsigned NUM_REGS = 7
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [ADDR_W-1:0]          rd_addr,
   output logic [DATA_W-1:0]          rd_data,
   output logic [NUM_REGS*DATA_W-1:0] cfg_flat
);

   logic [DATA_W-1:0] word [NUM_REGS];

   for (genvar g = 0; g < int'(NUM_REGS); g++) begin : g_word
      localparam logic [DATA_W-1:0] RST = DATA_W'(cfg_reset_value(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word[g] <= RST;
         end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
            word[g] <= wr_data;
         end
      end

      assign cfg_flat[g*DATA_W +: DATA_W] = word[g];
   end

   // Unmapped addresses read as zero.
   always_comb begin
      rd_data = '0;
      for (int i = 0; i < int'(NUM_REGS); i++) begin
         if (rd_addr == ADDR_W'(i)) rd_data = word[i];
      end
   end

endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
   import cfg_serial_pkg::*;
#(
   parameter int unsigned DATA_W      = CFG_WORD_W,
   parameter int unsigned ADDR_W      = CFG_ADDR_W,
   parameter int unsigned NUM_REGS    = CFG_WORDS,
   parameter int unsigned SYNC_STAGES = CFG_SYNC_N
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ser_clk,
   input  logic                       ser_sel_n,
   input  logic                       ser_din,
   output logic                       ser_dout,
   output logic                       ser_doe,
   output logic [NUM_REGS*DATA_W-1:0] cfg_flat
);

   if (NUM_REGS > (1 << ADDR_W)) begin : g_bad_regs
      $error("NUM_REGS exceeds the address space");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DATA_W < CFG_WORD_W) begin : g_bad_width
      $error("DATA_W too narrow for the reset values");
   end

   logic [2:0]        raw_in;
   logic [2:0]        sync_out;
   logic              sclk_s;
   logic              sel_n_s;
   logic              din_s;
   logic              wr_en;
   logic [ADDR_W-1:0] cmd_addr;
   logic [DATA_W-1:0] cmd_data;
   logic [DATA_W-1:0] rd_data;

   assign raw_in = {ser_din, ser_sel_n, ser_clk};

   cfg_serial_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b010)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (sync_out)
   );

   assign sclk_s  = sync_out[0];
   assign sel_n_s = sync_out[1];
   assign din_s   = sync_out[2];

   cfg_serial_frame #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk_s   (sclk_s),
      .sel_n_s  (sel_n_s),
      .din_s    (din_s),
      .rd_data  (rd_data),
      .wr_en    (wr_en),
      .cmd_addr (cmd_addr),
      .cmd_data (cmd_data),
      .ser_dout (ser_dout),
      .ser_doe  (ser_doe)
   );

   cfg_serial_regs #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .NUM_REGS (NUM_REGS)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (cmd_addr),
      .wr_data  (cmd_data),
      .rd_addr  (cmd_addr),
      .rd_data  (rd_data),
      .cfg_flat (cfg_flat)
   );

endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk #(
   parameter int unsigned DATA_W   = 11,
   parameter int unsigned NUM_REGS = 7
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       sel_n_s,
   input logic                       wr_en,
   input logic                       ser_doe,
   input logic                       ser_dout,
   input logic [NUM_REGS*DATA_W-1:0] cfg_flat
);

   // R3: stored words change only after a write strobe from the framer.
   assert_cfg_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_flat) |-> $past(wr_en));

   // R3: a write strobe only occurs with select high.
   assert_write_with_sel_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> sel_n_s);

   // R5: output enable turns on only on a select-high edge that is not a write.
   assert_doe_rise_on_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_doe) |-> ($past(sel_n_s) && !$past(wr_en)));

   // R6: output enable turns off only on a select-high edge and without writing.
   assert_doe_fall_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_doe) |-> ($past(sel_n_s) && !$past(wr_en)));

   // R5: while driving, the pin only advances during a low-select frame.
   assert_dout_moves_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_doe && $past(ser_doe) && !$stable(ser_dout)) |-> !$past(sel_n_s));

endmodule

bind cfg_serial_port cfg_serial_port_chk #(
   .DATA_W   (DATA_W),
   .NUM_REGS (NUM_REGS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sel_n_s  (sel_n_s),
   .wr_en    (wr_en),
   .ser_doe  (ser_doe),
   .ser_dout (ser_dout),
   .cfg_flat (cfg_flat)
);

// File: tb/cfg_serial_port_tb.sv
`timescale 1ns/1ps
module cfg_serial_port_tb;

   localparam int DW = 11;
   localparam int AW = 3;
   localparam int NR = 7;
   localparam int HALF = 6;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, sclk, sel_n, din;
   logic dout, doe;
   logic [NR*DW-1:0] cfg;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 0;

   logic [DW-1:0]    model [NR];
   logic [DW+AW-1:0] exp_q [$];
   logic [DW+AW-1:0] act_q [$];
   event             rd_ev;

   cfg_serial_port u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ser_clk   (sclk),
      .ser_sel_n (sel_n),
      .ser_din   (din),
      .ser_dout  (dout),
      .ser_doe   (doe),
      .cfg_flat  (cfg)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bit_cycle(input logic s_n, input logic d, output logic q);
      @(negedge clk);
      sel_n = s_n;
      din   = d;
      repeat (HALF) @(negedge clk);
      q    = dout;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
   endtask

   task automatic send_frame(input logic rw, input logic [AW-1:0] a, input logic [DW-1:0] d);
      logic [DW+AW:0] w;
      logic           q;
      w = {d, a, rw};
      for (int i = 0; i < DW+AW+1; i++) bit_cycle(1'b0, w[i], q);
      bit_cycle(1'b1, 1'b1, q);   // commit edge, data input high and ignored
   endtask

   task automatic write_reg(input logic [AW-1:0] a, input logic [DW-1:0] d);
      send_frame(1'b0, a, d);
      if (a < NR) model[a] = d;
   endtask

   task automatic check_cfg(input string req);
      for (int i = 0; i < NR; i++) check(req, 32'(cfg[i*DW +: DW]), 32'(model[i]));
   endtask

   // Driver side of a read: pushes the expected word, captures the actual one.
   task automatic read_reg(input logic [AW-1:0] a, input int extra);
      logic [DW+AW-1:0] cap;
      logic [DW+AW:0]   junk;
      logic             q;
      exp_q.push_back({(a < NR) ? model[a] : {DW{1'b0}}, a});
      send_frame(1'b1, a, '0);
      for (int k = 0; k < extra; k++) bit_cycle(1'b1, 1'b0, q);
      check("R5 R4 doe after read command", 32'(doe), 32'd1);
      // During readout the host wire carries a full write of 0x7FF to word 1.
      junk = {11'h7FF, 3'd1, 1'b0};
      for (int i = 0; i < DW+AW+1; i++) begin
         bit_cycle(1'b0, junk[i], q);
         if (i < DW+AW) cap[i] = q;
      end
      bit_cycle(1'b1, 1'b0, q);
      check("R6 doe released after readout", 32'(doe), 32'd0);
      check("R9 dout idle low", 32'(dout), 32'd0);
      check_cfg("R6 no write from readout frame");
      act_q.push_back(cap);
      -> rd_ev;
   endtask

   // Monitor: compares captured readouts against the expected queue.
   initial begin
      forever begin
         @(rd_ev);
         while (act_q.size() > 0 && exp_q.size() > 0) begin
            logic [DW+AW-1:0] a_v, e_v;
            a_v = act_q.pop_front();
            e_v = exp_q.pop_front();
            check("R5 R7 readback", 32'(a_v), 32'(e_v));
         end
      end
   end

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R1-watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic q;
      sclk  = 1'b0;
      sel_n = 1'b1;
      din   = 1'b0;
      rst_n = 1'b0;
      model[0] = 11'h04F; model[1] = 11'h003; model[2] = 11'h006;
      model[3] = 11'h013; model[4] = 11'h5DC; model[5] = 11'h5C1;
      model[6] = 11'h047;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1 reset contents, R9 idle pin
      check_cfg("R1 reset value");
      check("R9 doe after reset", 32'(doe), 32'd0);
      check("R9 dout after reset", 32'(dout), 32'd0);
      for (int a = 0; a < NR; a++) read_reg(AW'(a), 0);

      // R2 R3 single write
      write_reg(3'd0, 11'h5A3);
      check_cfg("R2 R3 write word 0");

      // R3 several patterns
      write_reg(3'd3, 11'h2AA);
      write_reg(3'd6, 11'h7FF);
      write_reg(3'd4, 11'h000);
      write_reg(3'd2, 11'h001);
      check_cfg("R3 write patterns");

      // R7 unmapped address
      write_reg(3'd7, 11'h555);
      check_cfg("R7 write to address 7 ignored");
      read_reg(3'd7, 0);

      // R4 extra select-high edges between read halves
      read_reg(3'd0, 2);
      read_reg(3'd3, 0);
      read_reg(3'd6, 1);

      // R8 overlong frame: three leading stray bits
      bit_cycle(1'b0, 1'b1, q);
      bit_cycle(1'b0, 1'b1, q);
      bit_cycle(1'b0, 1'b1, q);
      write_reg(3'd5, 11'h3C5);
      check_cfg("R8 last fifteen bits form the frame");
      read_reg(3'd5, 0);
      read_reg(3'd4, 0);

      repeat (20) @(negedge clk);
      done = 1;
      summary();
      $finish;
   end

endmodule